// File: doc/BRIEF.md
# Graphics Aperture Page Remapper

The remapper sits between a graphics master and system memory. It turns bus addresses that land inside a 256 MB graphics window into physical page addresses. Each 4 KB page of the window has one 32-bit entry in a page table held in memory. On a miss the block fetches that entry through a single-outstanding memory read port. It keeps the four most recent good translations in a small fully associative cache. Addresses outside the window, and every address while translation is off, come back unchanged.

Software programs the block through an 8-bit configuration port. The port has a page-table register (page-aligned table address plus entry count), a window base register, a control register, a status register and a fallback page register. Cache flushes and shutdown are done with short write sequences to the control register. Requests use a pulse and done protocol. The requester raises `xl_req` for one cycle and waits for the one-cycle `xl_done` before issuing the next request.

Top module: `aperture_remap`

## Requirements
- R1: After reset every configuration register reads 0, translation is off, and the status register reads 0x1 (idle, no error). Offsets are: table 0x8C, window base 0x90, control 0x94, status 0x98, fallback 0xA4.
- R2: The window base register keeps only bits [31:28], and its other bits read 0. The table register keeps the table page in [31:12] and the entry count in [11:0]. The fallback register keeps [31:12], and its low 12 bits read 0.
- R3: While control bit 8 (enable) is 0, or while address bits [31:28] differ from the window base, a request completes one cycle after it is taken. It returns `xl_paddr` equal to the request address with `xl_mapped`=0, and it issues no memory read.
- R4: On a cache miss with index = address[27:12] below the entry count, the block raises `mem_req` with `mem_addr` = table page address + 4 × index. It holds both stable until `mem_rvalid`.
- R5: The table word is little-endian. Entry byte 0 arrives on `mem_rdata[31:24]` and byte 3 arrives on `mem_rdata[7:0]`. Entry bit 0 (that is, `mem_rdata[24]`) marks a valid entry, and entry bits [31:12] give the physical page. A valid entry yields `xl_paddr` = {page, address[11:0]} with `xl_mapped`=1, one cycle after `mem_rvalid`.
- R6: An invalid entry, or an index at or above the entry count, yields {fallback page, address[11:0]} with `xl_fault`=1 and sets the sticky status bit 1. The count check issues no memory read. Writing status with bit 1 set clears that bit.
- R7: A request that hits the cache completes one cycle after it is taken, with no memory read. The cache holds four entries and replaces them round-robin, so the fifth distinct page that is filled evicts the first.
- R8: A control write with bit 0 set, or with bit 8 clear, empties the cache. Control bits 0, 8 and 16 read back as last written. The four-write sequence 0x101, 0x100, 0x10100, 0x100 leaves translation enabled with an empty cache.
- R9: A flush during a table walk does not stop the walk from returning its result, but that result is not cached.
- R10: The shutdown sequence 0x101, 0x0, 0x10000, 0x0 leaves translation off, so window addresses pass through unchanged.
- R11: Status bit 0 reads 1 only when no walk is in progress and `xl_req` is low.
- R12: Entries that fail validation are never cached, so a repeated access to the same page walks again.
- R13: `xl_done` is a one-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the addressed register (combinational) |
| xl_req | input | 1 | Translation request pulse |
| xl_addr | input | 32 | Bus address to translate |
| xl_done | output | 1 | Result valid pulse |
| xl_paddr | output | 32 | Translated or passed-through address |
| xl_mapped | output | 1 | Result came from the window path |
| xl_fault | output | 1 | Result used the fallback page |
| mem_req | output | 1 | Table read request, held until response |
| mem_addr | output | 32 | Table entry address |
| mem_rvalid | input | 1 | Table read response strobe |
| mem_rdata | input | 32 | Table word, lowest-address byte in [31:24] |

## Verification
The assertions assume that the requester never raises `xl_req` while a walk is in progress or in the cycle that `xl_done` is high. They also assume that `mem_rvalid` comes only while `mem_req` is high, and for exactly one cycle per request. The bench's request task waits for `xl_done` before it returns, so requests never overlap. Its memory model answers once per rising request after a fixed delay, so the response rules always hold. Flushes and status reads during a walk go through the configuration port only, so no port protocol is bent.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter int CACHE_N = 4,
  parameter int PAGE_W  = 12,
  parameter int CNT_W   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        xl_req,
  input  logic [31:0] xl_addr,
  output logic        xl_done,
  output logic [31:0] xl_paddr,
  output logic        xl_mapped,
  output logic        xl_fault,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int PN_W  = 32 - PAGE_W;
  localparam int IDX_W = 28 - PAGE_W;
  localparam int PTR_W = (CACHE_N > 1) ? $clog2(CACHE_N) : 1;
  localparam logic [7:0] A_TBL = 8'h8C;
  localparam logic [7:0] A_APB = 8'h90;
  localparam logic [7:0] A_CTL = 8'h94;
  localparam logic [7:0] A_STS = 8'h98;
  localparam logic [7:0] A_FBK = 8'hA4;

  logic [PN_W-1:0]    tbl_page, fbk_page;
  logic [CNT_W-1:0]   tbl_cnt;
  logic [3:0]         ap_base;
  logic               ctl_inv, ctl_en, ctl_x2, err;
  logic               walking, stale;
  logic [27:0]        req_lo;
  logic [CACHE_N-1:0] c_vld;
  logic [IDX_W-1:0]   c_tag [CACHE_N];
  logic [PN_W-1:0]    c_pg  [CACHE_N];
  logic [PTR_W-1:0]   rr;
  logic               hit;
  logic [PN_W-1:0]    hit_pg;

  wire             ctl_wr = cfg_we && cfg_addr == A_CTL;
  wire             flush  = ctl_wr && (cfg_wdata[0] || !cfg_wdata[8]);
  wire [IDX_W-1:0] idx    = xl_addr[27:PAGE_W];
  wire             in_ap  = ctl_en && xl_addr[31:28] == ap_base;
  wire             oob    = 32'(idx) >= 32'(tbl_cnt);
  wire [31:0]      ent    = {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]};
  wire             resp   = walking && mem_rvalid;
  wire             fill   = resp && ent[0] && !stale && !flush;
  wire             take   = xl_req && !walking;
  wire             early_flt = take && in_ap && !hit && oob;
  wire             idle   = !walking && !xl_req;

  logic unused_ok;
  assign unused_ok = ^{cfg_wdata, ent};

  assign mem_req = walking;

  always_comb begin
    hit = 1'b0;
    hit_pg = '0;
    for (int i = 0; i < CACHE_N; i++)
      if (c_vld[i] && c_tag[i] == idx) begin
        hit = 1'b1;
        hit_pg = c_pg[i];
      end
  end

  always_comb begin
    case (cfg_addr)
      A_TBL:   cfg_rdata = {tbl_page, {PAGE_W{1'b0}}} | 32'(tbl_cnt);
      A_APB:   cfg_rdata = {ap_base, 28'h0};
      A_CTL:   cfg_rdata = {15'h0, ctl_x2, 7'h0, ctl_en, 7'h0, ctl_inv};
      A_STS:   cfg_rdata = {30'h0, err, idle};
      A_FBK:   cfg_rdata = {fbk_page, {PAGE_W{1'b0}}};
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_page <= '0;
      tbl_cnt  <= '0;
      ap_base  <= '0;
      fbk_page <= '0;
      ctl_inv  <= 1'b0;
      ctl_en   <= 1'b0;
      ctl_x2   <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_TBL) begin
        tbl_page <= cfg_wdata[31:PAGE_W];
        tbl_cnt  <= cfg_wdata[CNT_W-1:0];
      end
      if (cfg_we && cfg_addr == A_APB) ap_base <= cfg_wdata[31:28];
      if (cfg_we && cfg_addr == A_FBK) fbk_page <= cfg_wdata[31:PAGE_W];
      if (ctl_wr) begin
        ctl_inv <= cfg_wdata[0];
        ctl_en  <= cfg_wdata[8];
        ctl_x2  <= cfg_wdata[16];
      end
      if (cfg_we && cfg_addr == A_STS && cfg_wdata[1]) err <= 1'b0;
      if (early_flt || (resp && !ent[0])) err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walking   <= 1'b0;
      stale     <= 1'b0;
      req_lo    <= '0;
      mem_addr  <= '0;
      xl_done   <= 1'b0;
      xl_paddr  <= '0;
      xl_mapped <= 1'b0;
      xl_fault  <= 1'b0;
    end else begin
      xl_done  <= 1'b0;
      xl_fault <= 1'b0;
      if (walking) begin
        if (flush) stale <= 1'b1;
        if (mem_rvalid) begin
          walking   <= 1'b0;
          xl_done   <= 1'b1;
          xl_mapped <= 1'b1;
          xl_fault  <= !ent[0];
          xl_paddr  <= ent[0] ? {ent[31:PAGE_W], req_lo[PAGE_W-1:0]}
                              : {fbk_page, req_lo[PAGE_W-1:0]};
        end
      end else if (xl_req) begin
        if (!in_ap) begin
          xl_done   <= 1'b1;
          xl_mapped <= 1'b0;
          xl_paddr  <= xl_addr;
        end else if (hit) begin
          xl_done   <= 1'b1;
          xl_mapped <= 1'b1;
          xl_paddr  <= {hit_pg, xl_addr[PAGE_W-1:0]};
        end else if (oob) begin
          xl_done   <= 1'b1;
          xl_mapped <= 1'b1;
          xl_fault  <= 1'b1;
          xl_paddr  <= {fbk_page, xl_addr[PAGE_W-1:0]};
        end else begin
          walking  <= 1'b1;
          stale    <= flush;
          req_lo   <= xl_addr[27:0];
          mem_addr <= {tbl_page, {PAGE_W{1'b0}}} + 32'({idx, 2'b00});
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_vld <= '0;
      rr    <= '0;
    end else if (flush) begin
      c_vld <= '0;
    end else if (fill) begin
      c_vld[rr] <= 1'b1;
      rr <= (rr == PTR_W'(CACHE_N - 1)) ? '0 : rr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      c_tag[rr] <= req_lo[27:PAGE_W];
      c_pg[rr]  <= ent[31:PAGE_W];
    end
  end
endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter int N = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        xl_req,
  input logic [31:0] xl_addr,
  input logic        xl_done,
  input logic [31:0] xl_paddr,
  input logic        xl_mapped,
  input logic        xl_fault,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        ctl_en,
  input logic [3:0]  ap_base,
  input logic [N-1:0] c_vld
);
  // R3: a walk starts only from a request inside an enabled window
  assert_walk_needs_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(xl_req && ctl_en && xl_addr[31:28] == ap_base));

  assert_passthru_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && !xl_mapped) |-> (xl_paddr == $past(xl_addr) && !xl_fault));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_fault_on_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (xl_done && xl_mapped));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 8'h94 && (cfg_wdata[0] || !cfg_wdata[8])) |=> (c_vld == '0));

  assert_busy_not_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h98 && mem_req) |-> !cfg_rdata[0]);

  assert_window_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 8'h90) |-> (cfg_rdata[27:0] == 28'h0));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |=> !xl_done);
endmodule

bind aperture_remap aperture_remap_chk #(.N(CACHE_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xl_req(xl_req),
  .xl_addr(xl_addr), .xl_done(xl_done), .xl_paddr(xl_paddr),
  .xl_mapped(xl_mapped), .xl_fault(xl_fault), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .ctl_en(ctl_en),
  .ap_base(ap_base), .c_vld(c_vld)
);

// File: tb/tb_aperture_remap.sv
`timescale 1ns/1ps
module tb_aperture_remap;
  localparam logic [31:0] TBL_ADDR = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        xl_req = 1'b0;
  logic [31:0] xl_addr = 32'h0;
  logic        xl_done, xl_mapped, xl_fault, mem_req;
  logic [31:0] xl_paddr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;

  int n_chk = 0, n_fail = 0, walks = 0, mlat = 0;
  logic busy = 1'b0, finished = 1'b0;
  logic [31:0] last_maddr = 32'h0;
  logic [31:0] r_pa;
  logic r_map, r_flt, r_after;
  int r_lat;

  always #4 clk = ~clk;

  aperture_remap dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xl_req(xl_req),
    .xl_addr(xl_addr), .xl_done(xl_done), .xl_paddr(xl_paddr),
    .xl_mapped(xl_mapped), .xl_fault(xl_fault), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] tbl_entry(input int i);
    return {20'h40000 + 20'(i), 11'h0, (i != 5)};
  endfunction

  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (busy) begin
      if (mlat == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= swap(tbl_entry(int'((mem_addr - TBL_ADDR) >> 2)));
        busy <= 1'b0;
      end else mlat <= mlat - 1;
    end else if (mem_req && !mem_rvalid) begin
      busy <= 1'b1;
      mlat <= 2;
      walks <= walks + 1;
      last_maddr <= mem_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 8'h0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_addr = 8'h0;
  endtask

  task automatic wait_done();
    r_lat = 1;
    while (!xl_done && r_lat < 50) begin
      @(negedge clk);
      r_lat++;
    end
    r_pa = xl_paddr; r_map = xl_mapped; r_flt = xl_fault;
    @(negedge clk);
    r_after = xl_done;
  endtask

  task automatic xlate(input logic [31:0] a);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
    wait_done();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    cfg_rd(8'h8C, d); chk("R1 table reg", d, 32'h0);
    cfg_rd(8'h90, d); chk("R1 window reg", d, 32'h0);
    cfg_rd(8'h94, d); chk("R1 control reg", d, 32'h0);
    cfg_rd(8'hA4, d); chk("R1 fallback reg", d, 32'h0);
    cfg_rd(8'h98, d); chk("R1 R11 status idle", d, 32'h1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    cfg_wr(8'h90, 32'h8765_4321); cfg_rd(8'h90, d); chk("R2 window base", d, 32'h8000_0000);
    cfg_wr(8'h8C, 32'h0010_0010); cfg_rd(8'h8C, d); chk("R2 table reg", d, 32'h0010_0010);
    cfg_wr(8'hA4, 32'hDEAD_0ABC); cfg_rd(8'hA4, d); chk("R2 fallback reg", d, 32'hDEAD_0000);
  endtask

  task automatic t_pass();
    int w0 = walks;
    xlate(32'h8000_3123);
    chk("R3 disabled addr", r_pa, 32'h8000_3123);
    chk("R3 disabled mapped", 32'(r_map), 32'h0);
    chk("R3 disabled latency", r_lat, 1);
    cfg_wr(8'h94, 32'h100);
    xlate(32'h9000_1000);
    chk("R3 outside window addr", r_pa, 32'h9000_1000);
    chk("R3 no walk", walks, w0);
  endtask

  task automatic t_walk();
    int w0 = walks;
    xlate(32'h8000_3123);
    chk("R4 walk issued", walks, w0 + 1);
    chk("R4 entry address", last_maddr, 32'h0010_000C);
    chk("R5 translated addr", r_pa, 32'h4000_3123);
    chk("R5 mapped flags", {r_map, r_flt}, 2'b10);
    chk("R13 done pulse after walk", 32'(r_after), 32'h0);
  endtask

  task automatic t_hit();
    int w0 = walks;
    xlate(32'h8000_3ABC);
    chk("R7 hit addr", r_pa, 32'h4000_3ABC);
    chk("R7 hit latency", r_lat, 1);
    chk("R7 hit no walk", walks, w0);
    chk("R13 done pulse after hit", 32'(r_after), 32'h0);
  endtask

  task automatic t_fault();
    logic [31:0] d;
    int w0 = walks;
    xlate(32'h8000_5010);
    chk("R6 invalid entry walk addr", last_maddr, 32'h0010_0014);
    chk("R6 invalid entry fallback", r_pa, 32'hDEAD_0010);
    chk("R6 fault flag", 32'(r_flt), 32'h1);
    cfg_rd(8'h98, d); chk("R6 sticky error", d, 32'h3);
    xlate(32'h8000_5020);
    chk("R12 invalid not cached", walks, w0 + 2);
    cfg_wr(8'h98, 32'h2); cfg_rd(8'h98, d); chk("R6 error cleared", d, 32'h1);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    int w0 = walks;
    xlate(32'h8002_0044);
    chk("R6 beyond count fallback", r_pa, 32'hDEAD_0044);
    chk("R6 beyond count fault", 32'(r_flt), 32'h1);
    chk("R6 beyond count no walk", walks, w0);
    cfg_rd(8'h98, d); chk("R6 beyond count sticky", d, 32'h3);
    cfg_wr(8'h98, 32'h2);
  endtask

  task automatic t_rr();
    int w0;
    xlate(32'h8000_0000);
    xlate(32'h8000_1000);
    xlate(32'h8000_2000);
    xlate(32'h8000_4000);
    w0 = walks;
    xlate(32'h8000_0004);
    chk("R7 kept entry hits", walks, w0);
    chk("R7 kept entry addr", r_pa, 32'h4000_0004);
    xlate(32'h8000_3000);
    chk("R7 oldest evicted", walks, w0 + 1);
    chk("R7 refill addr", r_pa, 32'h4000_3000);
  endtask

  task automatic t_inval();
    logic [31:0] d;
    int w0;
    cfg_wr(8'h94, 32'h101);
    cfg_wr(8'h94, 32'h100);
    cfg_wr(8'h94, 32'h10100);
    cfg_rd(8'h94, d); chk("R8 control readback", d, 32'h0001_0100);
    cfg_wr(8'h94, 32'h100);
    cfg_rd(8'h94, d); chk("R8 enabled after sequence", d, 32'h100);
    w0 = walks;
    xlate(32'h8000_0008);
    chk("R8 cache emptied", walks, w0 + 1);
    chk("R8 translation still on", r_pa, 32'h4000_0008);
  endtask

  task automatic t_stale();
    logic [31:0] d;
    int w0 = walks;
    @(negedge clk);
    xl_req = 1'b1; xl_addr = 32'h8000_6008;
    cfg_rd(8'h98, d); chk("R11 pending request not idle", d & 32'h1, 32'h0);
    @(negedge clk);
    xl_req = 1'b0;
    cfg_rd(8'h98, d); chk("R11 walk not idle", d & 32'h1, 32'h0);
    cfg_wr(8'h94, 32'h101);
    wait_done();
    chk("R9 walk result returned", r_pa, 32'h4000_6008);
    xlate(32'h8000_6008);
    chk("R9 stale result not cached", walks, w0 + 2);
  endtask

  task automatic t_shutdown();
    logic [31:0] d;
    int w0;
    cfg_wr(8'h94, 32'h101);
    cfg_wr(8'h94, 32'h0);
    cfg_wr(8'h94, 32'h10000);
    cfg_wr(8'h94, 32'h0);
    cfg_rd(8'h94, d); chk("R10 control after shutdown", d, 32'h0);
    w0 = walks;
    xlate(32'h8000_6008);
    chk("R10 passes through", r_pa, 32'h8000_6008);
    chk("R10 unmapped", 32'(r_map), 32'h0);
    chk("R10 no walk", walks, w0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_pass();
    t_walk();
    t_hit();
    t_fault();
    t_oob();
    t_rr();
    t_inval();
    t_stale();
    t_shutdown();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R13 completion): got no end expected end");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule